// File: doc/BRIEF.md
# Multi-ring DMA interrupt coalescer

This block sits beside a packet DMA engine and merges its per-packet completion events into far fewer host interrupts. Every receive ring and every transmit ring keeps its own count of completions since its last interrupt. A receive ring interrupts when that count reaches its programmed frame threshold, or when a coarse timer runs out while completions are still waiting to be serviced. A transmit ring has no timer. It interrupts when its count reaches the threshold, or when the ring drains empty with completions still outstanding.

Software uses a simple valid/address/write register port. Through it, software programs a frame threshold for each ring and a timeout for each receive ring, and it reads and clears the per-ring and summary interrupt status. A mask selects which summary bits drive the single interrupt output. The timer advances on a tick made by dividing the block clock by a parameter. The default of 1024 gives ticks of about 8.192 us from a 125 MHz clock.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all registers read 0: the summary status (offset 0x00), the mask (0x04), the per-ring status words and every threshold and timeout register. irq is 0.
- R2: A receive ring n with a non-zero threshold N sets bit n of the receive ring status (0x08) and bit 13 of the summary status (0x00) once N completions have been counted, and not before.
- R3: A receive ring with a non-zero timeout T (low 16 bits of its timeout register) starts its timer on the first completion after its last interrupt. It interrupts after T ticks with no further completions. With nothing pending the timer does not run.
- R4: A receive ring whose threshold and timeout are both 0 never interrupts, whatever completions arrive.
- R5: An interrupt clears the ring's frame counter and timer, so the next interrupt needs a full new batch.
- R6: A transmit ring m with a non-zero threshold N sets bit m of the transmit ring status (0x0C) and bit 16 of the summary status once N completions have been counted, and not before.
- R7: A rising edge of a transmit ring's empty flag raises that ring's interrupt if at least one completion is pending. With none pending it has no effect.
- R8: Status bits are write-1-to-clear. A written 1 clears the bit, and a written 0 leaves it unchanged.
- R9: irq is 1 exactly when some summary status bit (13 or 16) is set and its mask bit at the same position in 0x04 is 1.
- R10: Receive ring n's timeout register is at 0x2C + 4*n and stores all 32 written bits, so the bits above the 16-bit timeout survive a read-modify-write. Receive thresholds are at 0x70 + 4*n and transmit thresholds at 0xB4 + 4*m. A threshold keeps only its low 9 bits (a write of 0xFFFF reads back 0x1FF).
- R11: The frame counter saturates at 511 and does not wrap. A completion that arrives in the same cycle as its ring's interrupt counts toward the next batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access valid |
| reg_write | input | 1 | Access is a write when 1 |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_done | input | 17 | Per-receive-ring completion pulse, one per cycle |
| tx_done | input | 4 | Per-transmit-ring completion pulse |
| tx_empty | input | 4 | Per-transmit-ring empty flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench checks the threshold boundary by confirming that a ring stays silent at one completion short of its threshold. A design that compared off by one would fire early or late. It checks that no count is carried over after an interrupt and that a completion landing in the interrupt cycle is kept; a design that got either wrong would fire a batch early or lose a frame. To test saturation it drives 600 completions into a silent ring and then raises the threshold to 511. A wrapping counter would hold 88 and stay quiet. It also checks that the timer does not start on an idle ring and that an empty edge with nothing pending is ignored; a careless design would raise spurious interrupts in both cases.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // Summary status bit positions decoded by the interrupt handler
   localparam int RX_SUM_BIT = 13;
   localparam int TX_SUM_BIT = 16;
   // Fixed register offsets
   localparam int STAT_OFS   = 'h00;
   localparam int MASK_OFS   = 'h04;
   localparam int RXST_OFS   = 'h08;
   localparam int TXST_OFS   = 'h0C;
   localparam int TMO_BASE   = 'h2C;
endpackage

// File: rtl/coal_tick_gen.sv
module coal_tick_gen #(
   parameter int DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("coal_tick_gen: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/coal_rx_ring.sv
module coal_rx_ring #(
   parameter int CNT_W = 9,
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             done,
   input  logic [CNT_W-1:0] thr,
   input  logic [TMO_W-1:0] tmo,
   output logic             fire
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [TMO_W-1:0] TMR_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [TMO_W-1:0] tmr_q;
   logic             run_q;
   logic             by_count, by_time;

   assign by_count = (thr != '0) && (cnt_q >= thr);
   assign by_time  = (tmo != '0) && run_q && (tmr_q >= tmo);
   assign fire     = by_count | by_time;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmr_q <= '0;
         run_q <= 1'b0;
      end else if (fire) begin
         // A completion in the firing cycle opens the next batch
         cnt_q <= done ? CNT_W'(1) : '0;
         run_q <= done;
         tmr_q <= '0;
      end else begin
         if (done && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (done) run_q <= 1'b1;
         if (run_q && tick && tmr_q != TMR_MAX) tmr_q <= tmr_q + 1'b1;
      end
   end
endmodule

// File: rtl/coal_tx_ring.sv
module coal_tx_ring #(
   parameter int CNT_W      = 9,
   parameter bit EMPTY_TRIG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             empty,
   input  logic [CNT_W-1:0] thr,
   output logic             fire
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             by_count, by_drain;

   assign by_count = (thr != '0) && (cnt_q >= thr);

   generate
      if (EMPTY_TRIG) begin : g_drain
         logic empty_q;
         always_ff @(posedge clk) begin
            if (!rst_n) empty_q <= 1'b1;
            else        empty_q <= empty;
         end
         assign by_drain = empty && !empty_q && (cnt_q != '0);
      end else begin : g_nodrain
         assign by_drain = 1'b0;
      end
   endgenerate

   assign fire = by_count | by_drain;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (fire)                     cnt_q <= done ? CNT_W'(1) : '0;
      else if (done && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
   import coal_pkg::*;
#(
   parameter int NUM_RX        = 17,
   parameter int NUM_TX        = 4,
   parameter int CNT_W         = 9,
   parameter int TMO_W         = 16,
   parameter int TICK_DIV      = 1024,
   parameter int ADDR_W        = 8,
   parameter bit TX_EMPTY_TRIG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_RX-1:0] rx_done,
   input  logic [NUM_TX-1:0] tx_done,
   input  logic [NUM_TX-1:0] tx_empty,
   output logic              irq
);
   localparam int RXT_BASE = TMO_BASE + 4 * NUM_RX;
   localparam int TXT_BASE = RXT_BASE + 4 * NUM_RX;
   localparam int MAP_END  = TXT_BASE + 4 * NUM_TX;

   generate
      if (NUM_RX < 1 || NUM_RX > 32) begin : g_chk_rx
         $error("dma_irq_coalescer: NUM_RX must be 1..32");
      end
      if (NUM_TX < 1 || NUM_TX > 32) begin : g_chk_tx
         $error("dma_irq_coalescer: NUM_TX must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32 || TMO_W < 1 || TMO_W > 32) begin : g_chk_w
         $error("dma_irq_coalescer: field widths must be 1..32");
      end
      if (MAP_END > (1 << ADDR_W)) begin : g_chk_map
         $error("dma_irq_coalescer: register map exceeds address space");
      end
   endgenerate

   logic                         wr_en;
   logic                         tick;
   logic [NUM_RX-1:0][31:0]      rx_tmo_q;
   logic [NUM_RX-1:0][TMO_W-1:0] rx_tmo_w;
   logic [NUM_RX-1:0][CNT_W-1:0] rx_thr_q;
   logic [NUM_TX-1:0][CNT_W-1:0] tx_thr_q;
   logic [NUM_RX-1:0]            rx_fire;
   logic [NUM_TX-1:0]            tx_fire;
   logic [NUM_RX-1:0]            rx_st_q;
   logic [NUM_TX-1:0]            tx_st_q;
   logic                         rx_sum_q, tx_sum_q;
   logic [31:0]                  mask_q;

   assign wr_en = reg_valid && reg_write;

   coal_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   // Receive rings: storage, write decode and coalescing engine
   generate
      for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
         localparam logic [ADDR_W-1:0] A_TMO = ADDR_W'(TMO_BASE + 4 * i);
         localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(RXT_BASE + 4 * i);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rx_tmo_q[i] <= '0;
               rx_thr_q[i] <= '0;
            end else if (wr_en) begin
               if (reg_addr == A_TMO) rx_tmo_q[i] <= reg_wdata;
               if (reg_addr == A_THR) rx_thr_q[i] <= reg_wdata[CNT_W-1:0];
            end
         end
         assign rx_tmo_w[i] = rx_tmo_q[i][TMO_W-1:0];
         coal_rx_ring #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_ring (
            .clk(clk), .rst_n(rst_n), .tick(tick), .done(rx_done[i]),
            .thr(rx_thr_q[i]), .tmo(rx_tmo_w[i]), .fire(rx_fire[i])
         );
      end
   endgenerate

   // Transmit rings
   generate
      for (genvar j = 0; j < NUM_TX; j++) begin : g_tx
         localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(TXT_BASE + 4 * j);
         always_ff @(posedge clk) begin
            if (!rst_n)                           tx_thr_q[j] <= '0;
            else if (wr_en && reg_addr == A_THR)  tx_thr_q[j] <= reg_wdata[CNT_W-1:0];
         end
         coal_tx_ring #(.CNT_W(CNT_W), .EMPTY_TRIG(TX_EMPTY_TRIG)) u_ring (
            .clk(clk), .rst_n(rst_n), .done(tx_done[j]), .empty(tx_empty[j]),
            .thr(tx_thr_q[j]), .fire(tx_fire[j])
         );
      end
   endgenerate

   // Status (write-1-to-clear, a new event wins over a clear) and mask
   logic wr_stat, wr_rxst, wr_txst;
   assign wr_stat = wr_en && reg_addr == ADDR_W'(STAT_OFS);
   assign wr_rxst = wr_en && reg_addr == ADDR_W'(RXST_OFS);
   assign wr_txst = wr_en && reg_addr == ADDR_W'(TXST_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_st_q  <= '0;
         tx_st_q  <= '0;
         rx_sum_q <= 1'b0;
         tx_sum_q <= 1'b0;
         mask_q   <= '0;
      end else begin
         rx_st_q  <= (rx_st_q & ~(wr_rxst ? reg_wdata[NUM_RX-1:0] : '0)) | rx_fire;
         tx_st_q  <= (tx_st_q & ~(wr_txst ? reg_wdata[NUM_TX-1:0] : '0)) | tx_fire;
         rx_sum_q <= (rx_sum_q && !(wr_stat && reg_wdata[RX_SUM_BIT])) || (|rx_fire);
         tx_sum_q <= (tx_sum_q && !(wr_stat && reg_wdata[TX_SUM_BIT])) || (|tx_fire);
         if (wr_en && reg_addr == ADDR_W'(MASK_OFS)) mask_q <= reg_wdata;
      end
   end

   assign irq = (rx_sum_q && mask_q[RX_SUM_BIT]) || (tx_sum_q && mask_q[TX_SUM_BIT]);

   // Read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(STAT_OFS)) begin
         reg_rdata[RX_SUM_BIT] = rx_sum_q;
         reg_rdata[TX_SUM_BIT] = tx_sum_q;
      end
      if (reg_addr == ADDR_W'(MASK_OFS)) reg_rdata = mask_q;
      if (reg_addr == ADDR_W'(RXST_OFS)) reg_rdata[NUM_RX-1:0] = rx_st_q;
      if (reg_addr == ADDR_W'(TXST_OFS)) reg_rdata[NUM_TX-1:0] = tx_st_q;
      for (int i = 0; i < NUM_RX; i++) begin
         if (reg_addr == ADDR_W'(TMO_BASE + 4 * i)) reg_rdata = rx_tmo_q[i];
         if (reg_addr == ADDR_W'(RXT_BASE + 4 * i)) reg_rdata[CNT_W-1:0] = rx_thr_q[i];
      end
      for (int j = 0; j < NUM_TX; j++) begin
         if (reg_addr == ADDR_W'(TXT_BASE + 4 * j)) reg_rdata[CNT_W-1:0] = tx_thr_q[j];
      end
   end
endmodule

// File: rtl/coal_chk.sv
module coal_chk
   import coal_pkg::*;
#(
   parameter int NUM_RX = 17,
   parameter int NUM_TX = 4,
   parameter int CNT_W  = 9,
   parameter int TMO_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         irq,
   input logic [31:0]                  mask_q,
   input logic                         rx_sum_q,
   input logic                         tx_sum_q,
   input logic [NUM_RX-1:0]            rx_fire,
   input logic [NUM_TX-1:0]            tx_fire,
   input logic [NUM_RX-1:0][CNT_W-1:0] rx_thr_q,
   input logic [NUM_RX-1:0][TMO_W-1:0] rx_tmo_w,
   input logic                         wr_en,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic [31:0]                  reg_wdata
);
   logic [NUM_RX-1:0] both_zero;
   always_comb begin
      for (int i = 0; i < NUM_RX; i++)
         both_zero[i] = (rx_thr_q[i] == '0) && (rx_tmo_w[i] == '0);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!irq && !rx_sum_q && !tx_sum_q));

   // R4
   silent_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((both_zero & rx_fire) == '0));

   // R2
   rx_sum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_fire) |=> rx_sum_q);

   // R6
   tx_sum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_fire) |=> tx_sum_q);

   // R8
   w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_sum_q) |-> $past(wr_en && reg_addr == ADDR_W'(STAT_OFS) && reg_wdata[RX_SUM_BIT]));

   // R9
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[RX_SUM_BIT] && !mask_q[TX_SUM_BIT]) |-> !irq);
endmodule

bind dma_irq_coalescer coal_chk #(
   .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .CNT_W(CNT_W), .TMO_W(TMO_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .mask_q(mask_q),
   .rx_sum_q(rx_sum_q), .tx_sum_q(tx_sum_q), .rx_fire(rx_fire), .tx_fire(tx_fire),
   .rx_thr_q(rx_thr_q), .rx_tmo_w(rx_tmo_w), .wr_en(wr_en),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_dma_irq_coalescer.sv
module tb_dma_irq_coalescer;
   localparam int NRX = 17;
   localparam int NTX = 4;
   localparam int DIV = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [NRX-1:0] rx_done = '0;
   logic [NTX-1:0] tx_done = '0, tx_empty = '0;
   logic        irq;

   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   dma_irq_coalescer #(.NUM_RX(NRX), .NUM_TX(NTX), .TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_done(rx_done), .tx_done(tx_done), .tx_empty(tx_empty), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rx_pulse(input int n);
      @(negedge clk); rx_done[n] = 1'b1;
      @(negedge clk); rx_done[n] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic tx_pulse(input int n);
      @(negedge clk); tx_done[n] = 1'b1;
      @(negedge clk); tx_done[n] = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [7:0] tmo_a(input int n); return 8'(8'h2C + 4 * n); endfunction
   function automatic logic [7:0] rxt_a(input int n); return 8'(8'h70 + 4 * n); endfunction
   function automatic logic [7:0] txt_a(input int n); return 8'(8'hB4 + 4 * n); endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); check("R1 status", d, 0);
      rd(8'h04, d); check("R1 mask", d, 0);
      rd(8'h08, d); check("R1 rx ring status", d, 0);
      rd(tmo_a(16), d); check("R1 timeout16", d, 0);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(tmo_a(16), 32'hABCD_0005);
      rd(8'h6C, d); check("R10 timeout16 full word", d, 32'hABCD_0005);
      rd(d[7:0] & 8'h00, d);
      rd(8'h6C, d);
      wr(8'h6C, (d & 32'hFFFF_0000) | 32'h0000_0000);
      rd(8'h6C, d); check("R10 upper bits kept", d, 32'hABCD_0000);
      wr(rxt_a(0), 32'h0000_FFFF);
      rd(8'h70, d); check("R10 threshold 9 bits", d, 32'h1FF);
      wr(rxt_a(0), 0);
      wr(8'h6C, 0);
   endtask

   task automatic t_rx_count();
      logic [31:0] d;
      wr(rxt_a(3), 4);
      for (int k = 0; k < 3; k++) rx_pulse(3);
      rd(8'h08, d); check("R2 not before threshold", d, 0);
      rd(8'h00, d); check("R2 summary not before", d, 0);
      rx_pulse(3);
      rd(8'h08, d); check("R2 ring bit at threshold", d, 32'h8);
      rd(8'h00, d); check("R2 summary bit 13", d, 32'h2000);
      wr(8'h08, 0);
      rd(8'h08, d); check("R8 write 0 keeps", d, 32'h8);
      wr(8'h08, 32'h8);
      rd(8'h08, d); check("R8 write 1 clears ring", d, 0);
      // R9 masking with summary bit 13 still set
      check("R9 masked off", {31'b0, irq}, 0);
      wr(8'h04, 32'h2000);
      check("R9 enabled", {31'b0, irq}, 1);
      wr(8'h00, 0);
      rd(8'h00, d); check("R8 summary write 0 keeps", d, 32'h2000);
      wr(8'h00, 32'h2000);
      rd(8'h00, d); check("R8 summary cleared", d, 0);
      check("R9 cleared irq", {31'b0, irq}, 0);
      // R5: new batch needs a full count
      for (int k = 0; k < 3; k++) rx_pulse(3);
      rd(8'h08, d); check("R5 counter restarted", d, 0);
      rx_pulse(3);
      rd(8'h08, d); check("R5 full batch fires", d, 32'h8);
      wr(8'h08, 32'h8); wr(8'h00, 32'h2000);
      wr(rxt_a(3), 0);
   endtask

   task automatic t_rx_timeout();
      logic [31:0] d;
      wr(tmo_a(7), 3);
      repeat (100) @(negedge clk);
      rd(8'h08, d); check("R3 idle timer quiet", d, 0);
      @(negedge clk); rx_done[7] = 1'b1;
      @(negedge clk); rx_done[7] = 1'b0;
      repeat (24) @(negedge clk);
      rd(8'h08, d); check("R3 not before timeout", d, 0);
      repeat (36) @(negedge clk);
      rd(8'h08, d); check("R3 timeout fires", d, 32'h80);
      wr(8'h08, 32'h80); wr(8'h00, 32'h2000);
      repeat (100) @(negedge clk);
      rd(8'h08, d); check("R5 timer cleared by fire", d, 0);
      wr(tmo_a(7), 0);
   endtask

   task automatic t_rx_silent();
      logic [31:0] d;
      for (int k = 0; k < 20; k++) rx_pulse(9);
      repeat (100) @(negedge clk);
      rd(8'h08, d); check("R4 both zero never fires", d, 0);
   endtask

   task automatic t_rx_sat();
      logic [31:0] d;
      @(negedge clk); rx_done[2] = 1'b1;
      repeat (600) @(negedge clk);
      rx_done[2] = 1'b0;
      wr(rxt_a(2), 511);
      repeat (2) @(negedge clk);
      rd(8'h08, d); check("R11 saturated count fires at 511", d, 32'h4);
      wr(8'h08, 32'h4);
      wr(rxt_a(2), 2);
      @(negedge clk); rx_done[2] = 1'b1;
      repeat (3) @(negedge clk);
      rx_done[2] = 1'b0;
      repeat (2) @(negedge clk);
      wr(8'h08, 32'h4);
      rd(8'h08, d); check("R11 cleared before carry test", d, 0);
      rx_pulse(2);
      rd(8'h08, d); check("R11 same-cycle completion carried", d, 32'h4);
      wr(8'h08, 32'h4); wr(8'h00, 32'h2000);
      wr(rxt_a(2), 0);
   endtask

   task automatic t_tx();
      logic [31:0] d;
      wr(txt_a(1), 3);
      tx_pulse(1); tx_pulse(1);
      rd(8'h0C, d); check("R6 not before threshold", d, 0);
      tx_pulse(1);
      rd(8'h0C, d); check("R6 tx ring bit", d, 32'h2);
      rd(8'h00, d); check("R6 summary bit 16", d, 32'h1_0000);
      wr(8'h04, 32'h1_0000);
      check("R9 tx enabled", {31'b0, irq}, 1);
      wr(8'h0C, 32'h2); wr(8'h00, 32'h1_0000);
      check("R9 tx cleared", {31'b0, irq}, 0);
      tx_pulse(2);
      @(negedge clk); tx_empty[2] = 1'b1;
      repeat (3) @(negedge clk);
      rd(8'h0C, d); check("R7 drain with pending fires", d, 32'h4);
      wr(8'h0C, 32'h4); wr(8'h00, 32'h1_0000);
      @(negedge clk); tx_empty[2] = 1'b0;
      @(negedge clk); tx_empty[2] = 1'b1;
      repeat (3) @(negedge clk);
      rd(8'h0C, d); check("R7 drain with none pending ignored", d, 0);
      check("R7 irq stays low", {31'b0, irq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_rx_count();
      t_rx_timeout();
      t_rx_silent();
      t_rx_sat();
      t_tx();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule